// File: doc/BRIEF.md
# Low/Full-Speed USB Packet Line Transmitter

This block turns a stream of packet bytes into the line symbols of a low- or full-speed USB link. A byte source offers bytes on a valid/ready handshake, with a flag on the final byte of the packet. On every bit-time strobe the block moves the line on by one symbol. A packet begins with the synchronisation pattern. The bytes follow, least-significant bit first. A zero is inserted after any run of six ones, and the line level flips on every zero bit. The packet closes with two bit times of single-ended zero and one bit time of J, and the bus then goes back to idle.

The block only serialises. The byte source supplies the PID and the CRC fields. One speed input selects which wire polarity stands for J. When a packet is in flight, the output enable marks the bit times in which the block owns the bus.

Top module: `usb_bit_tx`

## Requirements
- R1: After reset `oeOut` is 0, `inReady` is 0 and the lines show J (full speed: `dpOut`=1, `dmOut`=0).
- R2: When `inValid` is high at a strobe while idle, that strobe and the next seven produce K J K J K J K K, and `oeOut` rises together with the first K.
- R3: Data bits are sent least-significant bit first. A 0 bit toggles the line between J and K, and a 1 bit keeps the line level.
- R4: After six consecutive 1 bits the block inserts one extra bit time that toggles the line. The run counts the final 1 of the sync pattern and continues across byte boundaries. Any toggle, whether from a data 0 or an inserted bit, restarts the count.
- R5: An inserted bit uses a full bit time and takes no byte: `inReady` stays 0 during it.
- R6: After the last bit of the byte flagged by `inLast`, including any inserted bit still due, the line shows SE0 (`dpOut`=`dmOut`=0) for two bit times and then J for one bit time. The line then returns to idle J.
- R7: `oeOut` is 1 from the first sync symbol through the J bit time that ends the packet, and 0 at every other strobe.
- R8: The outputs change only on a clock edge where `bitStb` was high, unless `lowSpeed` changes.
- R9: With `lowSpeed`=0, J is `dpOut`=1/`dmOut`=0. With `lowSpeed`=1, J is `dpOut`=0/`dmOut`=1. K is the inverse of J, and both lines high never occurs.
- R10: `inReady` is high only during a strobe cycle in which the next data bit is needed. A packet of N bytes completes exactly N handshakes.
- R11: While idle, strobes without `inValid` leave `oeOut` at 0 and the lines at J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitStb | input | 1 | One-cycle pulse per bit time |
| lowSpeed | input | 1 | 1 selects low-speed line polarity |
| inData | input | 8 | Packet byte |
| inValid | input | 1 | Byte offered |
| inLast | input | 1 | Offered byte is the final one |
| inReady | output | 1 | Byte taken this cycle |
| dpOut | output | 1 | Positive data line |
| dmOut | output | 1 | Negative data line |
| oeOut | output | 1 | Line driver enable |

## Verification
An all-zero byte makes the line toggle on every bit, which exposes a reversed NRZI sense or a wrong bit order. A mixed three-byte packet shows that the bytes arrive in the right order and that the handshake count is correct. Two bytes of 0xFF carry a run of ones across a byte boundary and force two inserted bits, which separates a run counter that resets per byte from one that does not. A final byte of 0xFC ends in six ones, so an inserted bit falls between the data and the SE0. A low-speed packet checks the inverted polarity, and an idle stretch shows that strobes alone start nothing.

// File: rtl/usb_bit_tx_pkg.sv
package usb_bit_tx_pkg;

  typedef enum logic [1:0] {
    SYM_J   = 2'd0,
    SYM_K   = 2'd1,
    SYM_SE0 = 2'd2
  } lineSym_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEND  = 3'd1,
    ST_EOP_A = 3'd2,
    ST_EOP_B = 3'd3,
    ST_EOP_J = 3'd4
  } txState_e;

  // control -> datapath strobes, at most one high per cycle
  typedef struct packed {
    logic loadSync;
    logic loadByte;
    logic shiftBit;
    logic stuffBit;
    logic driveSe0;
    logic driveJ;
    logic relBus;
  } txCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic stuffDue;
    logic bitsEmpty;
    logic lastTaken;
  } txStat_t;

endpackage

// File: rtl/usb_bit_tx_ctrl.sv
module usb_bit_tx_ctrl
  import usb_bit_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitStb,
  input  logic    inValid,
  input  txStat_t stat,
  output txCmd_t  cmd,
  output logic    inReady
);

  txState_e state, stateNext;

  // a byte is needed only when the shifter is empty, no stuff bit is pending
  // and the final byte has not been taken yet
  always_comb begin
    inReady = (state == ST_SEND) && bitStb && !stat.stuffDue &&
              stat.bitsEmpty && !stat.lastTaken;
  end

  always_comb begin
    cmd       = '0;
    stateNext = state;
    if (bitStb) begin
      unique case (state)
        ST_IDLE: begin
          if (inValid) begin
            cmd.loadSync = 1'b1;
            stateNext    = ST_SEND;
          end
        end
        ST_SEND: begin
          if (stat.stuffDue) begin
            cmd.stuffBit = 1'b1;
          end else if (!stat.bitsEmpty) begin
            cmd.shiftBit = 1'b1;
          end else if (inReady && inValid) begin
            cmd.loadByte = 1'b1;
          end else begin
            cmd.driveSe0 = 1'b1;
            stateNext    = ST_EOP_A;
          end
        end
        ST_EOP_A: begin
          cmd.driveSe0 = 1'b1;
          stateNext    = ST_EOP_B;
        end
        ST_EOP_B: begin
          cmd.driveJ = 1'b1;
          stateNext  = ST_EOP_J;
        end
        ST_EOP_J: begin
          cmd.relBus = 1'b1;
          stateNext  = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/usb_bit_tx_dp.sv
module usb_bit_tx_dp
  import usb_bit_tx_pkg::*;
#(
  parameter int                BYTE_W    = 8,
  parameter int                STUFF_RUN = 6,
  parameter logic [BYTE_W-1:0] SYNC_PAT  = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowSpeed,
  input  txCmd_t            cmd,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output txStat_t           stat,
  output logic              dpOut,
  output logic              dmOut,
  output logic              oeOut
);

  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam logic [CNT_W-1:0]  BITS_AFTER_FIRST = CNT_W'(BYTE_W - 1);
  localparam logic [ONES_W-1:0] RUN_LIMIT        = ONES_W'(STUFF_RUN);

  logic [BYTE_W-1:0] shReg;
  logic [CNT_W-1:0]  bitsLeft;
  logic [ONES_W-1:0] onesCnt;
  logic              lastTaken;
  logic              lvlK;
  logic              oeReg;
  lineSym_e          sym;

  logic              emitOn;
  logic              srcBit;
  logic              baseLvl;
  logic [ONES_W-1:0] baseOnes;
  logic              nextLvl;
  logic [ONES_W-1:0] nextOnes;

  always_comb begin
    emitOn   = cmd.loadSync | cmd.loadByte | cmd.shiftBit | cmd.stuffBit;
    srcBit   = cmd.loadSync ? SYNC_PAT[0] :
               cmd.loadByte ? inData[0]   :
               cmd.shiftBit ? shReg[0]    : 1'b0;
    // a new packet always encodes from the idle level
    baseLvl  = cmd.loadSync ? 1'b0 : lvlK;
    baseOnes = cmd.loadSync ? '0 : onesCnt;
    nextLvl  = srcBit ? baseLvl : ~baseLvl;
    nextOnes = srcBit ? baseOnes + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      bitsLeft  <= '0;
      onesCnt   <= '0;
      lastTaken <= 1'b0;
      lvlK      <= 1'b0;
      oeReg     <= 1'b0;
      sym       <= SYM_J;
    end else begin
      if (emitOn) begin
        lvlK    <= nextLvl;
        onesCnt <= nextOnes;
        sym     <= nextLvl ? SYM_K : SYM_J;
      end
      if (cmd.loadSync) begin
        shReg     <= SYNC_PAT >> 1;
        bitsLeft  <= BITS_AFTER_FIRST;
        lastTaken <= 1'b0;
        oeReg     <= 1'b1;
      end
      if (cmd.loadByte) begin
        shReg     <= inData >> 1;
        bitsLeft  <= BITS_AFTER_FIRST;
        lastTaken <= inLast;
      end
      if (cmd.shiftBit) begin
        shReg    <= shReg >> 1;
        bitsLeft <= bitsLeft - 1'b1;
      end
      if (cmd.driveSe0) sym <= SYM_SE0;
      if (cmd.driveJ)   sym <= SYM_J;
      if (cmd.relBus) begin
        oeReg   <= 1'b0;
        sym     <= SYM_J;
        lvlK    <= 1'b0;
        onesCnt <= '0;
      end
    end
  end

  always_comb begin
    stat.stuffDue  = (onesCnt == RUN_LIMIT);
    stat.bitsEmpty = (bitsLeft == '0);
    stat.lastTaken = lastTaken;
  end

  // full speed: J = D+ high; low speed swaps the wires
  always_comb begin
    unique case (sym)
      SYM_J:   begin dpOut = ~lowSpeed; dmOut = lowSpeed;  end
      SYM_K:   begin dpOut = lowSpeed;  dmOut = ~lowSpeed; end
      default: begin dpOut = 1'b0;      dmOut = 1'b0;      end
    endcase
    oeOut = oeReg;
  end

endmodule

// File: rtl/usb_bit_tx.sv
module usb_bit_tx
  import usb_bit_tx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStb,
  input  logic              lowSpeed,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              dpOut,
  output logic              dmOut,
  output logic              oeOut
);

  localparam logic [BYTE_W-1:0] SYNC_PAT = BYTE_W'(1) << (BYTE_W - 1);

  txCmd_t  dpCmd;
  txStat_t dpStat;

  usb_bit_tx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitStb  (bitStb),
    .inValid (inValid),
    .stat    (dpStat),
    .cmd     (dpCmd),
    .inReady (inReady)
  );

  usb_bit_tx_dp #(
    .BYTE_W    (BYTE_W),
    .STUFF_RUN (STUFF_RUN),
    .SYNC_PAT  (SYNC_PAT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lowSpeed (lowSpeed),
    .cmd      (dpCmd),
    .inData   (inData),
    .inLast   (inLast),
    .stat     (dpStat),
    .dpOut    (dpOut),
    .dmOut    (dmOut),
    .oeOut    (oeOut)
  );

endmodule

// File: rtl/usb_bit_tx_chk.sv
module usb_bit_tx_chk (
  input logic clk,
  input logic rstN,
  input logic bitStb,
  input logic lowSpeed,
  input logic inReady,
  input logic dpOut,
  input logic dmOut,
  input logic oeOut,
  input logic stuffDue
);

  // R1 / R7: with the driver released the line rests at J
  assert_idle_is_j_R1: assert property (@(posedge clk) disable iff (!rstN)
    !oeOut |-> (dpOut == ~lowSpeed && dmOut == lowSpeed));

  // R2: the first symbol of a packet is K
  assert_sop_is_k_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeOut) |-> (dpOut == lowSpeed && dmOut == ~lowSpeed));

  // R5: no byte is taken while an inserted bit is due
  assert_stuff_holds_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    stuffDue |-> !inReady);

  // R7: SE0 is only ever driven by an enabled driver
  assert_se0_driven_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!dpOut && !dmOut) |-> oeOut);

  // R8: nothing moves between bit times
  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(bitStb) && $stable(lowSpeed)) |-> $stable({dpOut, dmOut, oeOut}));

  // R9: both lines high is never produced
  assert_no_se1_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(dpOut && dmOut));

  // R10: a byte is only accepted on a strobe of a running packet
  assert_ready_on_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (bitStb && oeOut));

endmodule

bind usb_bit_tx usb_bit_tx_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .bitStb   (bitStb),
  .lowSpeed (lowSpeed),
  .inReady  (inReady),
  .dpOut    (dpOut),
  .dmOut    (dmOut),
  .oeOut    (oeOut),
  .stuffDue (dpStat.stuffDue)
);

// File: tb/usb_bit_tx_tb.sv
module usb_bit_tx_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STB_DIV    = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitStb = 1'b0;
  logic       lowSpeed = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady, dpOut, dmOut, oeOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] pkt [0:15];
  int         pktLen;
  int         expSym [0:255];  // 0 = J, 1 = K, 2 = SE0
  int         nExp;

  usb_bit_tx u_dut (
    .clk(clk), .rstN(rstN), .bitStb(bitStb), .lowSpeed(lowSpeed),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .dpOut(dpOut), .dmOut(dmOut), .oeOut(oeOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: got %0d cycles exp < 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input string got, input string exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: got %s exp %s", what, got, exp);
    end
  endtask

  // bench model: level per bit, inserted toggle after six ones
  int mLvl, mOnes;
  task automatic pushBit(input bit b);
    if (!b) mLvl = 1 - mLvl;
    mOnes = b ? mOnes + 1 : 0;
    expSym[nExp] = mLvl; nExp = nExp + 1;
    if (mOnes == 6) begin
      mLvl = 1 - mLvl; mOnes = 0;
      expSym[nExp] = mLvl; nExp = nExp + 1;
    end
  endtask

  task automatic buildExp();
    nExp = 0; mLvl = 0; mOnes = 0;
    for (int i = 0; i < 8; i++) pushBit((8'h80 >> i) & 1);
    for (int j = 0; j < pktLen; j++)
      for (int i = 0; i < 8; i++) pushBit(pkt[j][i]);
    expSym[nExp] = 2; nExp = nExp + 1;
    expSym[nExp] = 2; nExp = nExp + 1;
    expSym[nExp] = 0; nExp = nExp + 1;
  endtask

  function automatic logic [2:0] symLines(input int s, input bit ls, input bit oe);
    case (s)
      0:       return {~ls, ls, oe};
      1:       return {ls, ~ls, oe};
      default: return {2'b00, oe};
    endcase
  endfunction

  // drives one packet (or an idle stretch when pktLen is 0) and checks every strobe
  task automatic runPacket(input bit ls, input int nIdle, input string tag);
    int idx = 0, k = 0, cyc = 0, readyCnt = 0;
    bit prevStb = 0;
    logic [2:0] lastObs, expL;
    if (pktLen > 0) buildExp(); else nExp = 0;
    @(negedge clk);
    lowSpeed = ls;
    #1 lastObs = {dpOut, dmOut, oeOut};
    while (k < nExp + nIdle) begin
      @(negedge clk);
      if (prevStb) begin
        if (k < nExp) expL = symLines(expSym[k], ls, 1'b1);
        else          expL = symLines(0, ls, 1'b0);
        check({dpOut, dmOut, oeOut} == expL,
              $sformatf("%s %s bit time %0d dp/dm/oe", tag, (k < 8) ? "R2 R7" : "R3 R6 R7", k),
              $sformatf("%b", {dpOut, dmOut, oeOut}), $sformatf("%b", expL));
        k = k + 1;
      end else begin
        check({dpOut, dmOut, oeOut} == lastObs, $sformatf("%s R8 hold between strobes", tag),
              $sformatf("%b", {dpOut, dmOut, oeOut}), $sformatf("%b", lastObs));
      end
      lastObs = {dpOut, dmOut, oeOut};
      bitStb  = (cyc % STB_DIV) == 0;
      cyc     = cyc + 1;
      inValid = idx < pktLen;
      inData  = (idx < pktLen) ? pkt[idx] : 8'h00;
      inLast  = (idx == pktLen - 1);
      #1;
      if (inReady && inValid) begin
        readyCnt = readyCnt + 1;
        idx = idx + 1;
      end
      prevStb = bitStb;
    end
    @(negedge clk);
    bitStb = 0; inValid = 0; inLast = 0;
    check(readyCnt == pktLen, $sformatf("%s R10 handshake count", tag),
          $sformatf("%0d", readyCnt), $sformatf("%0d", pktLen));
  endtask

  task automatic testReset();
    check(oeOut == 1'b0 && inReady == 1'b0 && dpOut == 1'b1 && dmOut == 1'b0,
          "R1 reset state oe/ready/dp/dm",
          $sformatf("%b%b%b%b", oeOut, inReady, dpOut, dmOut), "0010");
  endtask

  task automatic testIdle();
    pktLen = 0;
    runPacket(1'b0, 8, "R11 idle strobes");
  endtask

  task automatic testZeros();
    pktLen = 1; pkt[0] = 8'h00;
    runPacket(1'b0, 2, "R3 zero byte");
  endtask

  task automatic testMixed();
    pktLen = 3; pkt[0] = 8'hC3; pkt[1] = 8'h5A; pkt[2] = 8'h01;
    runPacket(1'b0, 2, "R3 R10 three bytes");
  endtask

  task automatic testStuffSpan();
    pktLen = 2; pkt[0] = 8'hFF; pkt[1] = 8'hFF;
    runPacket(1'b0, 2, "R4 R5 ones across bytes");
  endtask

  task automatic testStuffTail();
    pktLen = 1; pkt[0] = 8'hFC;
    runPacket(1'b0, 2, "R4 R6 stuff before eop");
  endtask

  task automatic testLowSpeed();
    pktLen = 2; pkt[0] = 8'hA5; pkt[1] = 8'h3C;
    runPacket(1'b1, 2, "R9 low speed");
    @(negedge clk);
    lowSpeed = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdle();
    testZeros();
    testMixed();
    testStuffSpan();
    testStuffTail();
    testLowSpeed();
    testZeros();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule